// File: doc/BRIEF.md
# Floating-Point Round-and-Pack Unit

This unit turns an intermediate floating-point value into a finished IEEE-754 binary word. The value arrives as a sign bit, a signed unbiased exponent and a 64-bit significand whose leading one is explicit. That leading one carries the weight two to the power of the exponent. The unit finds the leading one and adds the format bias. It then aligns the significand for either a normal or a subnormal result, rounds it, and packs sign, exponent field and fraction into one word. Parameters set the exponent and fraction widths, so one description yields half, single or double results.

Two rounding modes are available. The first is round to nearest with ties to even. The second is round to odd, which suits a later re-rounding step. Each mode resolves overflow and complete underflow in its own way. The unit has one register stage. Results appear one clock after a valid input, together with a flag that marks a result differing from the exact value. Inputs are assumed finite; the unit does not accept infinities or NaNs.

Top module: `fp_round_pack`

## Requirements
- R1: A zero significand yields a word with only the sign bit taken from the input, and the inexact flag low.
- R2: For a normal result the exponent field equals the input exponent plus (2^EXP_W − 2)/2, and the leading one is dropped from the fraction. A significand that fits in the fraction is packed unchanged, and the inexact flag stays low.
- R3: With mode 0 (ties to even), a biased exponent above 2^EXP_W − 2 yields a signed infinity: exponent field all ones, fraction zero. No output ever has an all-ones exponent field with a nonzero fraction.
- R4: With mode 1 (round to odd), the same overflow yields the signed largest finite value: exponent field 2^EXP_W − 2, fraction all ones. In mode 1 the exponent field is never all ones.
- R5: A biased exponent of zero or below gives a subnormal result. The exponent field is 0, and the significand moves right by a further (1 − biased exponent) places.
- R6: When even the most significant input bit falls below half of the smallest subnormal step, mode 0 returns a signed zero. In that case mode 1 returns the signed smallest subnormal, with only fraction bit 0 set.
- R7: Mode 0 rounds to the nearest representable value. On an exact tie it picks the value whose fraction bit 0 is clear.
- R8: In mode 0 a rounding carry out of the fraction raises the exponent field. The largest subnormal can thus become the smallest normal, and the largest finite magnitude can become infinity.
- R9: In mode 1, when any discarded bit is nonzero, fraction bit 0 of the result is forced to 1. The remaining fraction bits are the truncated ones.
- R10: out_inexact is high when a nonzero bit was discarded, or when an overflow or complete-underflow rule set the result. Otherwise it is low.
- R11: Reset clears out_valid, out_word and out_inexact. A valid input appears at the outputs one clock later, with out_valid high.
- R12: While in_valid is low, out_valid falls on the next clock, and out_word and out_inexact keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value present this cycle |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_exp | input | EXPIN_W (16) | Signed unbiased exponent of the leading one |
| in_sig | input | SIG_W (64) | Significand with explicit leading one |
| in_rnd_mode | input | 1 | 0 = nearest, ties to even; 1 = round to odd |
| out_valid | output | 1 | Result present |
| out_word | output | 1+EXP_W+FRAC_W (32) | Packed IEEE-754 word |
| out_inexact | output | 1 | Result differs from the exact value |

## Verification
All state sits in the single output stage, so an internal fault shows as a wrong word or flag exactly one clock after the input that caused it. The faults most likely to go unseen involve one misplaced bit. These are a wrong leading-one position, an off-by-one alignment shift at the normal/subnormal boundary, a half bit chosen one place off, and a carry that stops short of the exponent field. Ties, all-ones significands and exponents on either side of each range limit show each of these as a one-ulp error, a missing exponent step or a wrong special value. Running half, single and double instances side by side on the same input stream exposes width-dependent slips in the bias and the field positions.

// File: rtl/fprp_pkg.sv
package fprp_pkg;

   typedef enum logic {
      RND_EVEN = 1'b0,
      RND_ODD  = 1'b1
   } rnd_mode_e;

endpackage

// File: rtl/fprp_lead_one.sv
module fprp_lead_one #(
   parameter int SIG_W = 64,
   parameter int POS_W = $clog2(SIG_W)
) (
   input  logic [SIG_W-1:0] sig_i,
   output logic [POS_W-1:0] pos_o,
   output logic             nz_o
);

   // priority encoder: highest set bit wins because it is visited last
   always_comb begin
      pos_o = '0;
      for (int i = 0; i < SIG_W; i++) begin
         if (sig_i[i]) pos_o = POS_W'(i);
      end
      nz_o = |sig_i;
   end

endmodule

// File: rtl/fprp_round.sv
module fprp_round
   import fprp_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int SIG_W   = 64,
   parameter int EXPIN_W = 16,
   parameter int POS_W   = $clog2(SIG_W)
) (
   input  logic                   sign_i,
   input  logic [EXPIN_W-1:0]     exp_i,
   input  logic [SIG_W-1:0]       sig_i,
   input  logic [POS_W-1:0]       lead_i,
   input  logic                   nz_i,
   input  rnd_mode_e              mode_i,
   output logic [EXP_W+FRAC_W:0]  word_o,
   output logic                   inexact_o
);

   localparam int WORD_W = EXP_W + FRAC_W + 1;
   localparam int CALC_W = EXPIN_W + 4;
   localparam int SH_W   = POS_W + 1;
   localparam logic signed [CALC_W-1:0] MAXN = CALC_W'((1 << EXP_W) - 2);
   localparam logic signed [CALC_W-1:0] BIAS = CALC_W'(((1 << EXP_W) - 2) >> 1);

   logic signed [CALC_W-1:0] bexp, lead_s, sh_norm, sh_sub, sh, neg_sh;
   logic                     is_sub, ovf, tiny, go_right, sticky, half, inc;
   logic [SH_W-1:0]          rsh, lsh, half_pos;
   logic [SIG_W-1:0]         mant, kept, lost_mask, half_vec, adj, adj_sh, frac_sel;
   logic [EXP_W-1:0]         exp_fld;
   logic [WORD_W-1:0]        packed_w;

   always_comb begin
      // range decisions on the biased exponent
      bexp    = CALC_W'($signed(exp_i)) + BIAS;
      lead_s  = $signed(CALC_W'(lead_i));
      sh_norm = lead_s - CALC_W'(FRAC_W);
      is_sub  = (bexp <= 0);
      ovf     = (bexp > MAXN);
      sh_sub  = sh_norm + CALC_W'(1) - bexp;
      tiny    = is_sub && (sh_sub > lead_s + CALC_W'(1));
      sh      = is_sub ? sh_sub : sh_norm;
      neg_sh  = -sh;
      go_right = (sh > 0);
      rsh     = sh[SH_W-1:0];
      lsh     = neg_sh[SH_W-1:0];

      // alignment
      mant      = is_sub ? sig_i : (sig_i & ~(SIG_W'(1) << lead_i));
      kept      = mant >> rsh;
      lost_mask = ~({SIG_W{1'b1}} << rsh);
      sticky    = |(mant & lost_mask);

      // nearest-even increment: drop one unit when half is set and kept lsb clear
      half_pos  = rsh - SH_W'(1);
      half_vec  = mant >> half_pos;
      half      = half_vec[0];
      adj       = mant - SIG_W'(half & ~kept[0]);
      adj_sh    = adj >> half_pos;
      inc       = adj_sh[0] && go_right && (mode_i == RND_EVEN);

      if (go_right)
         frac_sel = kept | SIG_W'((mode_i == RND_ODD) && sticky);
      else
         frac_sel = mant << lsh;

      exp_fld  = is_sub ? '0 : bexp[EXP_W-1:0];
      // carry out of the fraction walks into the exponent field
      packed_w = {sign_i, exp_fld, frac_sel[FRAC_W-1:0]} + WORD_W'(inc);

      word_o    = packed_w;
      inexact_o = go_right && sticky;

      if (!nz_i) begin
         word_o    = {sign_i, {(WORD_W-1){1'b0}}};
         inexact_o = 1'b0;
      end else if (ovf) begin
         inexact_o = 1'b1;
         if (mode_i == RND_ODD)
            word_o = {sign_i, MAXN[EXP_W-1:0], {FRAC_W{1'b1}}};
         else
            word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (tiny) begin
         inexact_o = 1'b1;
         word_o    = {sign_i, {(WORD_W-2){1'b0}}, (mode_i == RND_ODD)};
      end
   end

endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack
   import fprp_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int SIG_W   = 64,
   parameter int EXPIN_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_sign,
   input  logic [EXPIN_W-1:0]       in_exp,
   input  logic [SIG_W-1:0]         in_sig,
   input  logic                     in_rnd_mode,
   output logic                     out_valid,
   output logic [EXP_W+FRAC_W:0]    out_word,
   output logic                     out_inexact
);

   localparam int WORD_W = EXP_W + FRAC_W + 1;
   localparam int POS_W  = $clog2(SIG_W);

   // elaboration-time parameter checks
   if (EXP_W < 2 || EXP_W > 15) begin : g_bad_exp
      $error("fp_round_pack: EXP_W out of range");
   end
   if (FRAC_W < 1 || FRAC_W >= SIG_W - 1) begin : g_bad_frac
      $error("fp_round_pack: FRAC_W must be below SIG_W-1");
   end
   if (EXPIN_W <= EXP_W) begin : g_bad_expin
      $error("fp_round_pack: EXPIN_W must exceed EXP_W");
   end
   if ((1 << POS_W) != SIG_W) begin : g_bad_sig
      $error("fp_round_pack: SIG_W must be a power of two");
   end

   logic [POS_W-1:0]  lead;
   logic              nz;
   logic [WORD_W-1:0] word_c;
   logic              inexact_c;
   rnd_mode_e         mode;

   assign mode = rnd_mode_e'(in_rnd_mode);

   fprp_lead_one #(.SIG_W(SIG_W), .POS_W(POS_W)) u_lead (
      .sig_i (in_sig),
      .pos_o (lead),
      .nz_o  (nz)
   );

   fprp_round #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .SIG_W(SIG_W),
      .EXPIN_W(EXPIN_W), .POS_W(POS_W)
   ) u_round (
      .sign_i    (in_sign),
      .exp_i     (in_exp),
      .sig_i     (in_sig),
      .lead_i    (lead),
      .nz_i      (nz),
      .mode_i    (mode),
      .word_o    (word_c),
      .inexact_o (inexact_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_word    <= '0;
         out_inexact <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word    <= word_c;
            out_inexact <= inexact_c;
         end
      end
   end

   // R11
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_inexact)));
   // R1
   zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sig == '0) |=>
         (out_word == {$past(in_sign), {(WORD_W-1){1'b0}}} && !out_inexact));
   // R3
   no_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !((&out_word[WORD_W-2:FRAC_W]) && (|out_word[FRAC_W-1:0])));
   // R4
   odd_finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_rnd_mode) |=> !(&out_word[WORD_W-2:FRAC_W]));
   // R9
   odd_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_rnd_mode) |=> (!out_inexact || out_word[0]));

endmodule

// File: tb/fp_round_pack_tb_top.sv
module fp_round_pack_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sign = 1'b0;
   logic [15:0] in_exp = '0;
   logic [63:0] in_sig = '0;
   logic        in_rnd_mode = 1'b0;

   logic        v_h, v_s, v_d;
   logic        x_h, x_s, x_d;
   logic [15:0] w_h;
   logic [31:0] w_s;
   logic [63:0] w_d;

   always #4 clk = ~clk;

   if (1) begin : g_half
      fp_round_pack #(.EXP_W(5), .FRAC_W(10)) dut_i (
         .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
         .in_exp(in_exp), .in_sig(in_sig), .in_rnd_mode(in_rnd_mode),
         .out_valid(v_h), .out_word(w_h), .out_inexact(x_h));
   end
   if (1) begin : g_single
      fp_round_pack #(.EXP_W(8), .FRAC_W(23)) dut_i (
         .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
         .in_exp(in_exp), .in_sig(in_sig), .in_rnd_mode(in_rnd_mode),
         .out_valid(v_s), .out_word(w_s), .out_inexact(x_s));
   end
   if (1) begin : g_double
      fp_round_pack #(.EXP_W(11), .FRAC_W(52)) dut_i (
         .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
         .in_exp(in_exp), .in_sig(in_sig), .in_rnd_mode(in_rnd_mode),
         .out_valid(v_d), .out_word(w_d), .out_inexact(x_d));
   end

   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   string       cur_tag = "R11";
   logic [63:0] exp_w [3] = '{64'd0, 64'd0, 64'd0};
   logic        exp_x [3] = '{1'b0, 1'b0, 1'b0};
   logic        exp_v = 1'b0;
   int          EB [3] = '{5, 8, 11};
   int          FB [3] = '{10, 23, 52};

   // value = sig * 2^(ex - hsb); count result ulps, round, then encode
   function automatic void ref_model(input int eb, input int fb, input logic s,
                                     input longint ex, input logic [63:0] sg,
                                     input logic rto, output logic [63:0] w,
                                     output logic inx);
      longint bias, maxn, ulp, d, ef;
      int hsb;
      logic [63:0] n, rem, lowmask, sb;
      logic half, low;
      bias = ((longint'(1) << eb) - 2) >>> 1;
      maxn = (longint'(1) << eb) - 2;
      sb   = 64'(s) << (eb + fb);
      inx  = 1'b0;
      if (sg == 0) begin w = sb; return; end
      hsb = 0;
      for (int i = 0; i < 64; i++) if (sg[i]) hsb = i;
      if (ex + bias > maxn) begin
         inx = 1'b1;
         if (rto) w = sb | (64'(maxn) << fb) | ((64'd1 << fb) - 1);
         else     w = sb | (64'(maxn + 1) << fb);
         return;
      end
      ulp = (ex + bias >= 1) ? ex - fb : 1 - bias - fb;
      d   = ulp - (ex - hsb);
      if (d > hsb + 1) begin
         inx = 1'b1;
         w   = rto ? (sb | 64'd1) : sb;
         return;
      end
      if (d <= 0) begin
         n = sg << (-d);
      end else begin
         n       = (d >= 64) ? 64'd0 : (sg >> d);
         lowmask = (d >= 64) ? '1 : ((64'd1 << d) - 1);
         rem     = sg & lowmask;
         half    = sg[int'(d - 1)];
         low     = (sg & (lowmask >> 1)) != 0;
         if (rem != 0) inx = 1'b1;
         if (rto) begin
            if (rem != 0) n[0] = 1'b1;
         end else if (half && (low || n[0])) begin
            n = n + 1;
         end
      end
      if (n >= (64'd1 << (fb + 1))) begin n = n >> 1; ulp++; end
      if (n < (64'd1 << fb)) begin
         w = sb | n;
      end else begin
         ef = ulp + fb + bias;
         if (ef > maxn) w = sb | (64'(maxn + 1) << fb);
         else           w = sb | (64'(ef) << fb) | (n - (64'd1 << fb));
      end
   endfunction

   task automatic check_all();
      for (int k = 0; k < 3; k++) begin
         logic [63:0] gw;
         logic gx, gv;
         gw = (k == 0) ? {48'd0, w_h} : (k == 1) ? {32'd0, w_s} : w_d;
         gx = (k == 0) ? x_h : (k == 1) ? x_s : x_d;
         gv = (k == 0) ? v_h : (k == 1) ? v_s : v_d;
         n_chk++;
         if (gw !== exp_w[k] || gx !== exp_x[k] || gv !== exp_v) begin
            n_fail++;
            $display("FAIL %s e%0d/f%0d: got word=%h inexact=%b valid=%b, expected word=%h inexact=%b valid=%b",
                     cur_tag, EB[k], FB[k], gw, gx, gv, exp_w[k], exp_x[k], exp_v);
         end
      end
   endtask

   // check the previous cycle's result, then apply a new input
   task automatic step(input string tag, input logic v, input logic s,
                       input logic [15:0] e, input logic [63:0] g, input logic r);
      @(negedge clk);
      check_all();
      in_valid = v; in_sign = s; in_exp = e; in_sig = g; in_rnd_mode = r;
      if (v) begin
         for (int k = 0; k < 3; k++)
            ref_model(EB[k], FB[k], s, longint'($signed(e)), g, r, exp_w[k], exp_x[k]);
      end
      exp_v   = v;
      cur_tag = tag;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state is checked by the first step
      step("R1",  1, 1, 16'sd0,    64'd0, 0);
      step("R1",  1, 0, 16'sd40,   64'd0, 1);
      step("R2",  1, 0, 16'sd5,    64'h0000_0000_00C0_0000, 0);
      step("R2",  1, 1, -16'sd3,   64'h0000_0000_0000_0005, 0);
      step("R3",  1, 0, 16'sd200,  64'h8000_0000_0000_0000, 0);
      step("R3",  1, 1, 16'sd2000, 64'h1, 0);
      step("R4",  1, 0, 16'sd200,  64'h8000_0000_0000_0000, 1);
      step("R4",  1, 1, 16'sd2000, 64'h3, 1);
      step("R5",  1, 0, -16'sd130, 64'h8000_0000_0000_0000, 0);
      step("R5",  1, 0, -16'sd20,  64'h1, 0);
      step("R5",  1, 1, -16'sd1030,64'h0000_0000_0000_0003, 1);
      step("R6",  1, 1, -16'sd200, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      step("R6",  1, 1, -16'sd200, 64'hFFFF_FFFF_FFFF_FFFF, 1);
      step("R6",  1, 0, -16'sd1200,64'h1, 1);
      step("R6",  1, 0, -16'sd150, 64'h8000_0000_0000_0000, 0);
      step("R6",  1, 0, -16'sd150, 64'h8000_0000_0000_0001, 0);
      step("R7",  1, 0, 16'sd0,    64'h0000_0000_0100_0001, 0);
      step("R7",  1, 0, 16'sd0,    64'h0000_0000_0100_0003, 0);
      step("R7",  1, 0, 16'sd0,    64'h0000_0100_0001_0001, 0);
      step("R7",  1, 1, 16'sd0,    64'h0000_0000_0000_0801, 0);
      step("R7",  1, 0, 16'sd0,    64'h0000_0000_0000_0803, 0);
      step("R8",  1, 0, 16'sd0,    64'hFFFF_FFFF_FFFF_FFFF, 0);
      step("R8",  1, 0, 16'sd127,  64'hFFFF_FFFF_FFFF_FFFF, 0);
      step("R8",  1, 0, 16'sd15,   64'hFFFF_FFFF_FFFF_FFFF, 0);
      step("R8",  1, 0, 16'sd1023, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      step("R8",  1, 0, -16'sd127, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      step("R8",  1, 1, -16'sd15,  64'hFFFF_FFFF_FFFF_FFFF, 0);
      step("R8",  1, 0, -16'sd1023,64'hFFFF_FFFF_FFFF_FFFF, 0);
      step("R9",  1, 0, 16'sd0,    64'h0000_0000_0100_0001, 1);
      step("R9",  1, 1, 16'sd127,  64'hFFFF_FFFF_FFFF_FFFF, 1);
      step("R9",  1, 0, -16'sd127, 64'hFFFF_FFFF_FFFF_FFFF, 1);
      step("R10", 1, 0, 16'sd1,    64'h0000_0000_0000_0400, 0);
      step("R10", 1, 0, 16'sd1,    64'h0000_0000_0000_0401, 1);
      step("R12", 0, 1, 16'sd9,    64'h1234_5678_9ABC_DEF0, 1);
      step("R12", 0, 0, -16'sd9,   64'h0, 0);
      step("R11", 1, 1, 16'sd3,    64'h0000_0000_0000_0006, 0);
      for (int i = 0; i < 600; i++) begin
         logic [63:0] g;
         logic v;
         int e;
         g = {$urandom, $urandom} >> ($urandom % 64);
         if ($urandom % 4 == 0) g = g | (64'd1 << ($urandom % 40));
         e = int'($urandom % 2400) - 1200;
         v = ($urandom % 8) != 0;
         step(v ? "R10" : "R12", v, 1'($urandom), 16'(e), g, 1'($urandom));
      end
      step("R12", 0, 0, 16'sd0, 64'd0, 0);
      step("R12", 0, 0, 16'sd0, 64'd0, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule